// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the bus-facing half of a serial EEPROM that sits on a two-wire (I2C) bus. A fast system clock oversamples the SCL and SDA lines. The block recognises START and STOP conditions, shifts bits in and out, and decodes the device-select byte. It answers each byte with an acknowledge or a refusal and runs the write and read transactions. The storage itself lives elsewhere. Toward a page buffer and commit unit the block emits three one-cycle strobes: an address load, a data byte and a commit. It also reads the array through a plain combinational read port. A busy input from the commit unit makes the engine refuse its device address while a non-volatile write cycle is running, so a host can poll for completion.

The three extension bits of the device-select byte are shared between external select pins and the upper memory-address bits. `PIN_BITS` chooses how many of them are compared with pins; the rest become high address bits. The default, one pin bit, gives a 1 KiB (8 Kbit) array with 10-bit addresses. Sixteen-byte pages are the default (`PAGE_W` = 4).

Top module: `eep_slave_engine`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Before the first START the engine never pulls SDA, whatever the bus does. A STOP releases SDA and returns the engine to idle.
- R2: The engine captures bus data on SCL rising edges. It changes `sda_pull_o` only after an SCL falling edge, never while SCL stays high. `sda_pull_o`=1 means SDA is pulled low; the engine never drives SDA high.
- R3: The device-select byte is, MSB first: 1010, then three extension bits, then R/W (1 = read). The top `PIN_BITS` extension bits must equal `pins_i[2]` downward. With the default, bit 3 is compared with `pins_i[2]` and bits 2:1 are address bits 9:8. A wrong code or a wrong pin is refused, and the engine then stays silent until the next START.
- R4: The engine acknowledges a matching device byte, the word-address byte and each accepted write data byte. After the word-address byte it pulses `ld_addr_o` with `waddr_o` = {select-byte address bits, word byte}.
- R5: Each accepted write byte pulses `wr_byte_o` with its target in `waddr_o` and the byte in `wdata_o`. Consecutive bytes advance only the low `PAGE_W` address bits, so the address wraps inside the page.
- R6: `commit_o` pulses once on a STOP if at least one data byte was accepted since the last START. A repeated START discards this, and only one strobe is active in any cycle.
- R7: While `busy_i` is high when the device byte completes, the device byte is refused. Once `busy_i` clears, the device byte is acknowledged again.
- R8: `wp_i` is latched on the SCL falling edge that ends the word-address acknowledge. If it is high, the first data byte is refused, and neither `wr_byte_o` nor `commit_o` follows.
- R9: A read sends 8 bits MSB first, releases SDA for the ninth clock, and continues with the next byte while the host acknowledges. It stops driving after a host refusal.
- R10: A read with no word address starts at the internal address. The select-byte address bits are ignored for reads. The internal address is the last read location plus one, or, after a write, the location after the last byte written within its page.
- R11: A random read is a word-address write followed by a repeated START and a read; it returns the byte at that address.
- R12: A sequential read wraps from the last array location to address 0.
- R13: After reset SDA is released, no strobe is active and the internal address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| pins_i | input | 3 | Device-select straps, bit 2 compared first |
| wp_i | input | 1 | Write protect |
| busy_i | input | 1 | Non-volatile write cycle in progress |
| ld_addr_o | output | 1 | Word address loaded strobe |
| wr_byte_o | output | 1 | Write data byte strobe |
| commit_o | output | 1 | Commit the collected page strobe |
| waddr_o | output | ADDR_W | Address for ld_addr_o / wr_byte_o |
| wdata_o | output | 8 | Data for wr_byte_o |
| rd_addr_o | output | ADDR_W | Array read address |
| rd_data_i | input | 8 | Array read data, combinational from rd_addr_o |

## Verification
The bench targets the corners where a slave commonly goes wrong. It writes a run of 18 bytes so the page address must wrap. A design that carries into the upper bits would emit strobes outside the page. It reads across the top of the array, where wrapping at a page boundary instead of at the array end returns the wrong bytes. It asserts write protect and checks that no data strobe or commit appears. It polls a busy device and expects a refusal before an acknowledge. It aborts a write with a repeated START, where a design that commits anyway would raise busy and corrupt data. It also clocks bits with no START and sends mismatching device bytes, and on every clock it checks that SDA stays released while SCL is high in those phases.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD
  } eep_state_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[1] & scl_q;
  // SDA edge with SCL high on both samples
  assign start_o    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/eep_addr_decode.sv
module eep_addr_decode import eep_pkg::*; #(
  parameter int PIN_BITS = 1
) (
  input  logic [7:0] dev_i,
  input  logic [2:0] pins_i,
  output logic       hit_o,
  output logic       rd_o,
  output logic [2:0] hi_o
);
  logic pin_ok;
  logic unused_pins;

  generate
    if (PIN_BITS == 0) begin : g_no_pins
      assign pin_ok = 1'b1;
    end else begin : g_pins
      assign pin_ok = (dev_i[3 -: PIN_BITS] == pins_i[2 -: PIN_BITS]);
    end
  endgenerate

  assign unused_pins = ^pins_i;
  assign hit_o = (dev_i[7:4] == DEV_CODE) && pin_ok;
  assign rd_o  = dev_i[0];
  // pin-compared bits are masked so only memory-address bits remain
  assign hi_o  = dev_i[3:1] & (3'b111 >> PIN_BITS);
endmodule

// File: rtl/eep_slave_engine.sv
module eep_slave_engine import eep_pkg::*; #(
  parameter int PIN_BITS = 1,
  parameter int PAGE_W   = 4,
  localparam int EXT_W   = 3 - PIN_BITS,
  localparam int ADDR_W  = 8 + EXT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [2:0]        pins_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              ld_addr_o,
  output logic              wr_byte_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  eep_bus_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  eep_state_e        state;
  logic [7:0]        sh, tx;
  logic [3:0]        cnt;
  logic              pull, is_rd, wp_lat, wrote, mack;
  logic [2:0]        hi_lat;
  logic [ADDR_W-1:0] cur_addr, new_addr, page_next;
  logic              ld_q, wr_q, cm_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [7:0]        wdata_q;
  logic              dev_hit, dev_rd;
  logic [2:0]        dev_hi;
  logic              byte_in;

  eep_addr_decode #(.PIN_BITS(PIN_BITS)) u_dec (
    .dev_i  (sh),
    .pins_i (pins_i),
    .hit_o  (dev_hit),
    .rd_o   (dev_rd),
    .hi_o   (dev_hi)
  );

  assign byte_in   = (cnt == 4'd8);
  assign new_addr  = ADDR_W'({hi_lat, sh});
  assign page_next = {cur_addr[ADDR_W-1:PAGE_W], cur_addr[PAGE_W-1:0] + 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      sh       <= '0;
      tx       <= '0;
      cnt      <= '0;
      pull     <= 1'b0;
      is_rd    <= 1'b0;
      wp_lat   <= 1'b0;
      wrote    <= 1'b0;
      mack     <= 1'b0;
      hi_lat   <= '0;
      cur_addr <= '0;
      ld_q     <= 1'b0;
      wr_q     <= 1'b0;
      cm_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      ld_q <= 1'b0;
      wr_q <= 1'b0;
      cm_q <= 1'b0;
      if (bus_start) begin
        // fresh or repeated START: abort and take a device byte
        state <= ST_DEV;
        cnt   <= '0;
        pull  <= 1'b0;
        wrote <= 1'b0;
      end else if (bus_stop) begin
        state <= ST_IDLE;
        pull  <= 1'b0;
        cm_q  <= wrote;
        wrote <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && !byte_in) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && byte_in) begin
              if (state == ST_DEV) begin
                if (dev_hit && !busy_i) begin
                  pull   <= 1'b1;
                  is_rd  <= dev_rd;
                  hi_lat <= dev_hi;
                  state  <= ST_DEV_ACK;
                end else begin
                  pull  <= 1'b0;
                  state <= ST_HOLD;
                end
              end else if (state == ST_WADDR) begin
                pull     <= 1'b1;
                cur_addr <= new_addr;
                ld_q     <= 1'b1;
                waddr_q  <= new_addr;
                state    <= ST_WADDR_ACK;
              end else if (wp_lat) begin
                pull  <= 1'b0;
                state <= ST_HOLD;
              end else begin
                pull     <= 1'b1;
                wr_q     <= 1'b1;
                waddr_q  <= cur_addr;
                wdata_q  <= sh;
                cur_addr <= page_next;
                wrote    <= 1'b1;
                state    <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (is_rd) begin
                tx    <= rd_data_i;
                pull  <= ~rd_data_i[7];
                cnt   <= 4'd1;
                state <= ST_RDATA;
              end else begin
                pull  <= 1'b0;
                cnt   <= '0;
                state <= ST_WADDR;
              end
            end
          end
          ST_WADDR_ACK: begin
            if (scl_fall) begin
              pull   <= 1'b0;
              wp_lat <= wp_i;
              cnt    <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              pull  <= 1'b0;
              cnt   <= '0;
              state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (byte_in) begin
                pull     <= 1'b0;
                cur_addr <= cur_addr + 1'b1;
                state    <= ST_RACK;
              end else begin
                pull <= ~tx[6];
                tx   <= {tx[6:0], 1'b0};
                cnt  <= cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx    <= rd_data_i;
                pull  <= ~rd_data_i[7];
                cnt   <= 4'd1;
                state <= ST_RDATA;
              end else begin
                pull  <= 1'b0;
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull;
  assign ld_addr_o  = ld_q;
  assign wr_byte_o  = wr_q;
  assign commit_o   = cm_q;
  assign waddr_o    = waddr_q;
  assign wdata_o    = wdata_q;
  assign rd_addr_o  = cur_addr;
endmodule

// File: rtl/eep_slave_checks.sv
module eep_slave_checks import eep_pkg::*; (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s_i,
  input logic       scl_fall_i,
  input logic       stop_i,
  input logic       start_i,
  input logic       busy_i,
  input eep_state_e state_i,
  input logic [3:0] cnt_i,
  input logic       sda_pull_i,
  input logic       ld_i,
  input logic       wr_i,
  input logic       cm_i
);
  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_i, wr_i, cm_i}));

  p_drive_after_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_i) |-> $past(scl_fall_i));

  p_hold_while_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i)) |-> $stable(sda_pull_i));

  p_busy_nack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DEV && scl_fall_i && cnt_i == 4'd8 && busy_i && !start_i && !stop_i)
      |=> !sda_pull_i);

  p_stop_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_pull_i);

  p_commit_on_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_i |-> $past(stop_i));
endmodule

bind eep_slave_engine eep_slave_checks u_checks (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s_i    (scl_s),
  .scl_fall_i (scl_fall),
  .stop_i     (bus_stop),
  .start_i    (bus_start),
  .busy_i     (busy_i),
  .state_i    (state),
  .cnt_i      (cnt),
  .sda_pull_i (sda_pull_o),
  .ld_i       (ld_addr_o),
  .wr_i       (wr_byte_o),
  .cm_i       (commit_o)
);

// File: tb/eep_slave_engine_bench.sv
module eep_slave_engine_bench;
  localparam int Q    = 6;
  localparam int MEM  = 1024;
  localparam int BUSY = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, busy = 1'b0;
  logic sda_pull, ld, wr, cm;
  logic [9:0] waddr, rd_addr;
  logic [7:0] wdata, rd_data;
  logic line;
  logic [7:0] arr [MEM];

  assign line    = sda_m & ~sda_pull;
  assign rd_data = arr[rd_addr];

  eep_slave_engine u_eep_slave_engine (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(line),
    .sda_pull_o(sda_pull), .pins_i(3'b101), .wp_i(wp), .busy_i(busy),
    .ld_addr_o(ld), .wr_byte_o(wr), .commit_o(cm), .waddr_o(waddr),
    .wdata_o(wdata), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  int total = 0, bad = 0, busy_cnt = 0, exp_commit = 0;
  int exp_ld[$];
  int exp_wr[$];
  bit quiet = 1'b0, pull_seen = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // environment: strobe scoreboard, busy model, per-clock SDA watch
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_pull) pull_seen = 1'b1;
      if (quiet && scl_m) chk(!sda_pull, "R2 slave held SDA while host drives", 1, 0);
      if (ld) begin
        if (exp_ld.size() == 0) chk(0, "R4 unexpected address load", waddr, 0);
        else begin
          int e;
          e = exp_ld.pop_front();
          chk(waddr == e[9:0], "R4 loaded address", waddr, e);
        end
      end
      if (wr) begin
        if (exp_wr.size() == 0) chk(0, "R8 unexpected data strobe", {waddr, wdata}, 0);
        else begin
          int e;
          e = exp_wr.pop_front();
          chk({waddr, wdata} == e[17:0], "R5 data strobe addr/data", {waddr, wdata}, e);
        end
      end
      if (cm) begin
        if (exp_commit == 0) chk(0, "R6 unexpected commit", 1, 0);
        else exp_commit--;
        busy_cnt = BUSY;
      end
      if (busy_cnt > 0) busy_cnt--;
      busy = (busy_cnt > 0);
    end
  end

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, input bit q, output logic r);
    quiet = q; sda_m = b; half();
    scl_m = 1'b1; half();
    r = line; half();
    scl_m = 1'b0; half();
  endtask

  task automatic bus_start();
    quiet = 1'b1; sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic bus_stop();
    quiet = 1'b1; sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
    quiet = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], 1'b1, r);
    bit_io(1'b1, 1'b0, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, 1'b0, r);
      d[i] = r;
    end
    bit_io(~mack, 1'b1, r);
  endtask

  function automatic logic [7:0] devb(input bit rd, input logic [1:0] hi);
    return {4'b1010, 1'b1, hi, rd};
  endfunction

  task automatic poll(output int tries);
    logic ack;
    tries = 0;
    for (int k = 0; k < 20; k++) begin
      tries++;
      bus_start();
      send_byte(devb(1'b0, 2'b00), ack);
      bus_stop();
      if (ack) break;
    end
  endtask

  task automatic do_write(input int addr, input int n, input int seed, input bit prot);
    logic ack;
    int a, tries;
    logic [7:0] dat;
    bus_start();
    send_byte(devb(1'b0, addr[9:8]), ack);
    chk(ack, "R4 device byte ack", ack, 1);
    exp_ld.push_back(addr);
    send_byte(addr[7:0], ack);
    chk(ack, "R4 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      a = (addr & ~15) | ((addr + k) & 15);
      dat = 8'(seed + 13 * k);
      if (!prot) exp_wr.push_back(a * 256 + dat);
      send_byte(dat, ack);
      if (prot) begin
        chk(!ack, "R8 protected data byte refused", ack, 0);
        break;
      end
      chk(ack, "R4 data byte ack", ack, 1);
    end
    if (!prot) exp_commit++;
    bus_stop();
    repeat (10) @(negedge clk);
    chk(exp_ld.size() == 0 && exp_wr.size() == 0 && exp_commit == 0,
        "R6 strobes/commit match", exp_wr.size() + exp_commit, 0);
    if (!prot)
      for (int k = 0; k < n; k++) begin
        a = (addr & ~15) | ((addr + k) & 15);
        arr[a] = 8'(seed + 13 * k);
      end
    poll(tries);
    if (prot) chk(tries == 1, "R8 no write cycle after protected write", tries, 1);
    else begin
      chk(tries > 1, "R7 address refused while busy", tries, 2);
      chk(tries < 20, "R7 acknowledge returns after busy", tries, 2);
    end
  endtask

  task automatic rand_read(input int addr, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    int e;
    bus_start();
    send_byte(devb(1'b0, addr[9:8]), ack);
    chk(ack, "R11 dummy write device ack", ack, 1);
    exp_ld.push_back(addr);
    send_byte(addr[7:0], ack);
    chk(ack, "R11 dummy write address ack", ack, 1);
    bus_start();
    send_byte(devb(1'b1, 2'b00), ack);
    chk(ack, "R11 read device ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      e = arr[(addr + i) % MEM];
      chk(d == e[7:0], tag, d, e);
    end
    bus_stop();
  endtask

  task automatic cur_read(input logic [1:0] hi, input int ptr, input string tag);
    logic ack;
    logic [7:0] d;
    int e;
    bus_start();
    send_byte(devb(1'b1, hi), ack);
    chk(ack, "R10 read device ack", ack, 1);
    recv_byte(1'b0, d);
    e = arr[ptr % MEM];
    chk(d == e[7:0], tag, d, e);
    bus_stop();
  endtask

  initial begin
    logic ack, r;
    logic [7:0] d;
    int tries, e;
    for (int i = 0; i < MEM; i++) arr[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    chk(!sda_pull && !ld && !wr && !cm, "R13 outputs idle in reset", {sda_pull, ld, wr, cm}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_addr == 10'd0, "R13 internal address zero", rd_addr, 0);

    // R1: bits with no START
    pull_seen = 1'b0;
    scl_m = 1'b0; half();
    for (int i = 0; i < 18; i++) bit_io(devb(1'b0, 2'b00) >> (i % 8), 1'b1, r);
    bus_stop();
    chk(!pull_seen, "R1 no response before START", pull_seen, 0);

    // R10/R13: current read after reset, select bits ignored
    cur_read(2'b11, 0, "R10 current read from reset address");

    // R3: wrong code, then wrong pin
    pull_seen = 1'b0;
    bus_start();
    send_byte(8'hB2, ack);
    chk(!ack, "R3 wrong device code refused", ack, 0);
    send_byte(devb(1'b0, 2'b00), ack);
    chk(!pull_seen, "R3 silent until next START", pull_seen, 0);
    bus_stop();
    bus_start();
    send_byte(8'b1010_0000, ack);
    chk(!ack, "R3 wrong pin bit refused", ack, 0);
    bus_stop();

    // R4/R7/R11: single byte write then random read
    do_write(10'h1A5, 1, 8'h5C, 1'b0);
    rand_read(10'h1A5, 1, "R11 random read of written byte");

    // R5: 18 bytes wrap inside the page
    do_write(10'h2F3, 18, 8'h21, 1'b0);
    cur_read(2'b00, 10'h2F5, "R10 current address after page write");
    rand_read(10'h2F0, 16, "R9 sequential read of wrapped page");

    // R8: write protect
    wp = 1'b1;
    e = arr[10'h0C0];
    do_write(10'h0C0, 1, 8'h11, 1'b1);
    wp = 1'b0;
    rand_read(10'h0C0, 1, "R8 protected location unchanged");
    chk(arr[10'h0C0] == e[7:0], "R8 array model unchanged", arr[10'h0C0], e);

    // R6: repeated START after an accepted byte aborts the write
    bus_start();
    send_byte(devb(1'b0, 2'b01), ack);
    exp_ld.push_back(10'h155);
    send_byte(8'h55, ack);
    exp_wr.push_back(10'h155 * 256 + 8'h77);
    send_byte(8'h77, ack);
    chk(ack, "R4 data byte ack before abort", ack, 1);
    bus_start();
    send_byte(devb(1'b1, 2'b00), ack);
    chk(ack, "R6 read after repeated START ack", ack, 1);
    recv_byte(1'b0, d);
    e = arr[10'h156];
    chk(d == e[7:0], "R6 read continues after aborted byte", d, e);
    bus_stop();
    repeat (10) @(negedge clk);
    chk(exp_commit == 0 && exp_wr.size() == 0, "R6 no commit after abort", exp_commit, 0);
    poll(tries);
    chk(tries == 1, "R6 no write cycle after abort", tries, 1);
    rand_read(10'h155, 1, "R6 aborted location unchanged");

    // R12: wrap at end of array
    rand_read(10'h3FE, 4, "R12 sequential read wraps to zero");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule